// File: doc/BRIEF.md
# Mode-Banked Processor Register File

A 32-bit general-purpose register file for a processor core in which the physical storage behind an architectural register depends on the current operating mode. Two combinational read ports and one write port take a 4-bit architectural index together with a 5-bit mode code. Eight low registers are one shared set. The fast-interrupt mode has private copies of the whole upper group from index 8 to 14. Each of the other four exception modes keeps private copies of only its stack pointer (index 13) and link register (index 14).

The file also holds one current status register shared by all modes, and one saved-status register for each exception mode. Dedicated ports read and write the saved status of the current mode. An exception-entry side port writes, in one cycle, the saved status and the link register of the mode being entered. Index 15 is the program counter, which lives outside this block and is fed in on `pcIn`.

Top module: `bankedRegFile`

## Requirements
- R1: Mode codes are decoded as 5'b10000 user, 5'b10001 fast interrupt, 5'b10010 interrupt, 5'b10011 supervisor, 5'b10111 abort and 5'b11011 undefined. Any other code selects the user bank.
- R2: Indices 0 to 7 address one physical set, whatever the mode used to write or read them.
- R3: In fast-interrupt mode, indices 8 to 14 address copies that belong only to that mode. The user copies are unaffected by those writes.
- R4: In interrupt, supervisor, abort and undefined modes, indices 13 and 14 address copies private to each mode. Indices 8 to 12 address the user copies.
- R5: A read of index 15 on either port returns `pcIn`. A write to index 15 changes no stored register.
- R6: `statWrEn` loads `statWrData` into the single status register, and `statOut` shows it in every mode.
- R7: Each exception mode has its own saved status, read on `savedOut` and written with `savedWrEn`. In user mode, `savedOut` returns the status register and saved writes are ignored.
- R8: `entryEn` writes `entrySaved` into the saved status and `entryLink` into index 14 of the mode coded on `entryMode`, in the same cycle. It overrides a port write to the same register in that cycle. If `entryMode` decodes to user, it does nothing.
- R9: A write takes effect at the next rising clock edge. A read of the same register in the same cycle returns the old value.
- R10: While `rstN` is low, every stored register, including the status and saved-status registers, is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| modeIn | input | 5 | Current operating mode code |
| pcIn | input | 32 | Program counter value returned for index 15 |
| rdIdxA | input | 4 | Read port A index |
| rdDataA | output | 32 | Read port A data |
| rdIdxB | input | 4 | Read port B index |
| rdDataB | output | 32 | Read port B data |
| wrEn | input | 1 | Register write enable |
| wrIdx | input | 4 | Register write index |
| wrData | input | 32 | Register write data |
| statWrEn | input | 1 | Status register write enable |
| statWrData | input | 32 | Status register write data |
| statOut | output | 32 | Status register value |
| savedWrEn | input | 1 | Saved-status write enable for the current mode |
| savedWrData | input | 32 | Saved-status write data |
| savedOut | output | 32 | Saved status of the current mode |
| entryEn | input | 1 | Exception-entry bulk write enable |
| entryMode | input | 5 | Mode being entered |
| entrySaved | input | 32 | Saved status written on entry |
| entryLink | input | 32 | Link value written on entry |

## Verification
The assertions assume that `modeIn` and `entryMode` are valid 5-bit codes whenever reset is high, and that the entry check reads back in the mode that was entered. The entry check therefore only fires when `modeIn` equals the earlier `entryMode`. The stimulus takes both mode codes from a fixed list: the six legal codes and one unused code. Random write-enable mixes regularly make the entry port, the saved port and the register port hit the same register in one cycle. A behavioural model of each mode's view compares all four outputs before every rising edge.

// File: rtl/rfbank_pkg.sv
package rfbank_pkg;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;

  typedef enum logic [2:0] {
    BK_USR = 3'd0, BK_FIQ = 3'd1, BK_IRQ = 3'd2,
    BK_SVC = 3'd3, BK_ABT = 3'd4, BK_UND = 3'd5
  } bank_e;

  localparam int NUM_EXC   = 5;            // exception banks with saved status
  localparam int NUM_LOW   = 8;            // shared low registers
  localparam int NUM_HIGH  = 7;            // indices 8..14
  localparam int NUM_PRIV  = 2;            // stack + link per small bank
  localparam int NUM_PHYS  = NUM_LOW + 2 * NUM_HIGH + (NUM_EXC - 1) * NUM_PRIV;
  localparam int PHYS_W    = $clog2(NUM_PHYS);
  localparam int FIQ_BASE  = NUM_LOW + NUM_HIGH;
  localparam int PRIV_BASE = FIQ_BASE + NUM_HIGH;

  typedef struct packed {
    logic              rfWe;
    logic [PHYS_W-1:0] rfSel;
    logic              lkWe;
    logic [PHYS_W-1:0] lkSel;
    logic [NUM_EXC-1:0] svWe;
    logic [NUM_EXC-1:0] svEnt;
    logic              stWe;
    logic [PHYS_W-1:0] rdSelA;
    logic [PHYS_W-1:0] rdSelB;
    logic              pcA;
    logic              pcB;
    logic [2:0]        svSel;
    logic              svUser;
  } rfStrobes_t;

  function automatic bank_e decodeMode(input logic [4:0] m);
    case (m)
      MODE_FIQ: return BK_FIQ;
      MODE_IRQ: return BK_IRQ;
      MODE_SVC: return BK_SVC;
      MODE_ABT: return BK_ABT;
      MODE_UND: return BK_UND;
      default:  return BK_USR;
    endcase
  endfunction

endpackage

// File: rtl/rfCtrl.sv
module rfCtrl
  import rfbank_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [4:0] modeIn,
  input  logic [3:0] rdIdxA,
  input  logic [3:0] rdIdxB,
  input  logic       wrEn,
  input  logic [3:0] wrIdx,
  input  logic       statWrEn,
  input  logic       savedWrEn,
  input  logic       entryEn,
  input  logic [4:0] entryMode,
  output rfStrobes_t strobes
);

  bank_e curBank, entBank;

  function automatic logic [PHYS_W-1:0] physOf(input bank_e b, input logic [3:0] i);
    int r;
    if (int'(i) < NUM_LOW)
      r = int'(i);
    else if (b == BK_FIQ)
      r = FIQ_BASE + int'(i) - NUM_LOW;
    else if (int'(i) >= 13 && b != BK_USR)
      r = PRIV_BASE + NUM_PRIV * (int'(b) - 2) + (int'(i) - 13);
    else
      r = int'(i);
    return PHYS_W'(r);
  endfunction

  always_comb begin
    curBank = decodeMode(modeIn);
    entBank = decodeMode(entryMode);

    strobes        = '0;
    strobes.rfWe   = wrEn && (wrIdx != 4'd15);
    strobes.rfSel  = physOf(curBank, wrIdx);
    strobes.lkWe   = entryEn && (entBank != BK_USR);
    strobes.lkSel  = physOf(entBank, 4'd14);
    strobes.stWe   = statWrEn;
    strobes.rdSelA = physOf(curBank, rdIdxA);
    strobes.rdSelB = physOf(curBank, rdIdxB);
    strobes.pcA    = (rdIdxA == 4'd15);
    strobes.pcB    = (rdIdxB == 4'd15);
    strobes.svSel  = curBank;
    strobes.svUser = (curBank == BK_USR);
    for (int k = 0; k < NUM_EXC; k++) begin
      strobes.svEnt[k] = strobes.lkWe && (int'(entBank) == k + 1);
      strobes.svWe[k]  = strobes.svEnt[k] ||
                         (savedWrEn && (int'(curBank) == k + 1));
    end
  end

  // R8: at most one bank receives an entry write
  p_entry_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.svEnt));

  // R7: user mode without entry never writes a saved status
  p_user_no_saved_r7: assert property (@(posedge clk) disable iff (!rstN)
    (decodeMode(modeIn) == BK_USR && !entryEn) |-> (strobes.svWe == '0));

endmodule

// File: rtl/rfData.sv
module rfData
  import rfbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  rfStrobes_t        strobes,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] statWrData,
  input  logic [DATA_W-1:0] savedWrData,
  input  logic [DATA_W-1:0] entrySaved,
  input  logic [DATA_W-1:0] entryLink,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] statOut,
  output logic [DATA_W-1:0] savedOut
);

  logic [DATA_W-1:0] gpr [NUM_PHYS];
  logic [DATA_W-1:0] svReg [NUM_EXC];
  logic [DATA_W-1:0] stReg;
  logic [2:0]        svIdx;

  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_gpr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        gpr[p] <= '0;
      else if (strobes.lkWe && strobes.lkSel == PHYS_W'(p))
        gpr[p] <= entryLink;
      else if (strobes.rfWe && strobes.rfSel == PHYS_W'(p))
        gpr[p] <= wrData;
    end
  end

  for (genvar k = 0; k < NUM_EXC; k++) begin : g_saved
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        svReg[k] <= '0;
      else if (strobes.svWe[k])
        svReg[k] <= strobes.svEnt[k] ? entrySaved : savedWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           stReg <= '0;
    else if (strobes.stWe) stReg <= statWrData;
  end

  always_comb begin
    svIdx    = strobes.svSel - 3'd1;
    rdDataA  = strobes.pcA ? pcIn : gpr[strobes.rdSelA];
    rdDataB  = strobes.pcB ? pcIn : gpr[strobes.rdSelB];
    statOut  = stReg;
    savedOut = stReg;
    if (!strobes.svUser && int'(svIdx) < NUM_EXC)
      savedOut = svReg[svIdx];
  end

  // R9: a written register holds the written value one edge later
  p_write_lands_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rfWe && !(strobes.lkWe && strobes.lkSel == strobes.rfSel))
      |=> gpr[$past(strobes.rfSel)] == $past(wrData));

endmodule

// File: rtl/bankedRegFile.sv
module bankedRegFile
  import rfbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        modeIn,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [3:0]        rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdIdxB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              statWrEn,
  input  logic [DATA_W-1:0] statWrData,
  output logic [DATA_W-1:0] statOut,
  input  logic              savedWrEn,
  input  logic [DATA_W-1:0] savedWrData,
  output logic [DATA_W-1:0] savedOut,
  input  logic              entryEn,
  input  logic [4:0]        entryMode,
  input  logic [DATA_W-1:0] entrySaved,
  input  logic [DATA_W-1:0] entryLink
);

  rfStrobes_t strobes;

  rfCtrl u_ctrl (
    .clk, .rstN, .modeIn, .rdIdxA, .rdIdxB, .wrEn, .wrIdx,
    .statWrEn, .savedWrEn, .entryEn, .entryMode, .strobes
  );

  rfData #(.DATA_W(DATA_W)) u_data (
    .clk, .rstN, .strobes, .pcIn, .wrData, .statWrData, .savedWrData,
    .entrySaved, .entryLink, .rdDataA, .rdDataB, .statOut, .savedOut
  );

  // R5: index 15 always shows the external program counter
  p_pc_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdxB == 4'd15) |-> (rdDataB == pcIn));

  // R2: low registers written in one mode are seen the same way next cycle
  p_low_shared_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx < 4'd8) |=> ((rdIdxA == $past(wrIdx)) |-> (rdDataA == $past(wrData))));

  // R7: user mode saved read mirrors the status register
  p_user_saved_r7: assert property (@(posedge clk) disable iff (!rstN)
    (decodeMode(modeIn) == BK_USR) |-> (savedOut == statOut));

  // R8: entry write is visible in the entered mode on the next cycle
  p_entry_lands_r8: assert property (@(posedge clk) disable iff (!rstN)
    (entryEn && decodeMode(entryMode) != BK_USR)
      |=> ((modeIn == $past(entryMode)) |-> (savedOut == $past(entrySaved))));

endmodule

// File: tb/sim_bankedRegFile.sv
module sim_bankedRegFile;

  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  modeIn, entryMode;
  logic [31:0] pcIn, wrData, statWrData, savedWrData, entrySaved, entryLink;
  logic [3:0]  rdIdxA, rdIdxB, wrIdx;
  logic        wrEn, statWrEn, savedWrEn, entryEn;
  logic [31:0] rdDataA, rdDataB, statOut, savedOut;

  always #5 clk = ~clk;

  bankedRegFile u0 (.*);

  int nVec = 0, nBad = 0;
  bit done = 0;

  logic [4:0] codes [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                            5'b10111, 5'b11011, 5'b00101};

  // behavioural view: what each of the six modes sees at indices 0..14
  logic [31:0] view  [6][15];
  logic [31:0] mSaved[6];
  logic [31:0] mStat;

  function automatic int bankOf(logic [4:0] m);
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic bit shares(int a, int b, int i);
    if (i < 8)  return 1;
    if (i < 13) return (a == 1) == (b == 1);
    return a == b;
  endfunction

  task automatic modelWrite(int b, int i, logic [31:0] d);
    for (int k = 0; k < 6; k++)
      if (shares(b, k, i)) view[k][i] = d;
  endtask

  task automatic modelClear();
    for (int k = 0; k < 6; k++) begin
      mSaved[k] = '0;
      for (int i = 0; i < 15; i++) view[k][i] = '0;
    end
    mStat = '0;
  endtask

  function automatic logic [31:0] expRead(logic [3:0] idx);
    if (idx == 4'd15) return pcIn;
    return view[bankOf(modeIn)][idx];
  endfunction

  function automatic string rdTag(logic [3:0] idx);
    if (idx == 4'd15) return "R5";
    if (idx < 4'd8) return "R2";
    if (bankOf(modeIn) == 1) return "R3";
    return "R4";
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    wrEn = 0; statWrEn = 0; savedWrEn = 0; entryEn = 0;
  endtask

  // compare before the edge, then advance model at the edge
  task automatic cycle(string tag);
    int b;
    #2;
    b = bankOf(modeIn);
    cmp(tag == "" ? rdTag(rdIdxA) : tag, "rdDataA", rdDataA, expRead(rdIdxA));
    cmp(tag == "" ? rdTag(rdIdxB) : tag, "rdDataB", rdDataB, expRead(rdIdxB));
    cmp(tag == "" ? "R6" : tag, "statOut", statOut, mStat);
    cmp(tag == "" ? "R7" : tag, "savedOut", savedOut, b == 0 ? mStat : mSaved[b]);
    @(posedge clk);
    if (rstN) begin
      if (wrEn && wrIdx != 4'd15) modelWrite(b, int'(wrIdx), wrData);
      if (savedWrEn && b != 0) mSaved[b] = savedWrData;
      if (statWrEn) mStat = statWrData;
      if (entryEn && bankOf(entryMode) != 0) begin
        mSaved[bankOf(entryMode)] = entrySaved;
        modelWrite(bankOf(entryMode), 14, entryLink);
      end
    end
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    end
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rstN = 0; idle();
    modeIn = 5'b10000; entryMode = 5'b10000; pcIn = 32'h100;
    rdIdxA = 0; rdIdxB = 0; wrIdx = 0;
    wrData = 0; statWrData = 0; savedWrData = 0; entrySaved = 0; entryLink = 0;
    modelClear();
    repeat (3) @(negedge clk);
    rstN = 1;

    // R10: every register of every bank reads zero after reset
    for (int m = 0; m < 6; m++)
      for (int i = 0; i < 15; i++) begin
        modeIn = codes[m]; rdIdxA = 4'(i); rdIdxB = 4'(14 - i);
        cycle("R10");
      end

    // R1: stack pointer written under each code, read under each code
    for (int m = 0; m < 7; m++) begin
      modeIn = codes[m]; wrEn = 1; wrIdx = 13; wrData = 32'h1300 + 32'(m);
      cycle("R1");
    end
    idle();
    for (int m = 0; m < 7; m++) begin
      modeIn = codes[m]; rdIdxA = 13; rdIdxB = 14;
      cycle("R1");
    end

    // R3 / R4: upper group written in user and fast-interrupt, read everywhere
    for (int i = 8; i < 15; i++) begin
      modeIn = codes[0]; wrEn = 1; wrIdx = 4'(i); wrData = 32'hA000 + 32'(i);
      cycle("");
      modeIn = codes[1]; wrData = 32'hF000 + 32'(i);
      cycle("R3");
    end
    idle();
    for (int m = 0; m < 6; m++)
      for (int i = 8; i < 15; i++) begin
        modeIn = codes[m]; rdIdxA = 4'(i); rdIdxB = 4'(i - 8);
        cycle(m == 1 ? "R3" : "R4");
      end

    // R9: same-cycle read returns old value, next cycle returns new
    modeIn = codes[3]; wrEn = 1; wrIdx = 5; wrData = 32'h5555_AAAA;
    rdIdxA = 5; rdIdxB = 5;
    cycle("R9");
    idle();
    cycle("R9");

    // R5: writes to 15 are dropped, reads give pcIn
    wrEn = 1; wrIdx = 15; wrData = 32'hDEAD_BEEF; pcIn = 32'h0000_8000;
    rdIdxA = 15; rdIdxB = 14;
    cycle("R5");
    idle(); pcIn = 32'h0000_4004;
    cycle("R5");

    // R6 / R7: saved port in user mode is ignored; in interrupt mode it sticks
    modeIn = codes[0]; savedWrEn = 1; savedWrData = 32'h1111; statWrEn = 1;
    statWrData = 32'h6000_0010;
    cycle("R7");
    idle();
    cycle("R7");
    modeIn = codes[2]; savedWrEn = 1; savedWrData = 32'h2222;
    cycle("R7");
    idle();
    cycle("R7");
    modeIn = codes[3];
    cycle("R6");

    // R8: entry beats port writes to the same saved status and link
    modeIn = codes[3]; entryEn = 1; entryMode = codes[3];
    entrySaved = 32'hE5E5; entryLink = 32'hC0DE;
    wrEn = 1; wrIdx = 14; wrData = 32'hBAD0;
    savedWrEn = 1; savedWrData = 32'hBAD1;
    rdIdxA = 14; rdIdxB = 13;
    cycle("R8");
    idle();
    cycle("R8");
    // entry aimed at user mode changes nothing
    modeIn = codes[0]; entryEn = 1; entryMode = codes[0];
    entrySaved = 32'h7777; entryLink = 32'h8888;
    cycle("R8");
    idle();
    cycle("R8");
    modeIn = codes[4]; entryEn = 1; entryMode = codes[4];
    entrySaved = 32'hAB07; entryLink = 32'hAB14;
    cycle("R8");
    idle(); rdIdxA = 14;
    cycle("R8");

    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      modeIn      = codes[$urandom_range(0, 6)];
      entryMode   = codes[$urandom_range(0, 6)];
      rdIdxA      = 4'($urandom_range(0, 15));
      rdIdxB      = 4'($urandom_range(0, 15));
      wrIdx       = 4'($urandom_range(0, 15));
      wrEn        = ($urandom_range(0, 3) != 0);
      statWrEn    = ($urandom_range(0, 7) == 0);
      savedWrEn   = ($urandom_range(0, 3) == 0);
      entryEn     = ($urandom_range(0, 7) == 0);
      pcIn        = $urandom;
      wrData      = $urandom;
      statWrData  = $urandom;
      savedWrData = $urandom;
      entrySaved  = $urandom;
      entryLink   = $urandom;
      cycle("");
    end

    // R10: reset again in the middle of use
    idle(); rstN = 0; modelClear();
    @(negedge clk); rstN = 1;
    for (int m = 0; m < 6; m++) begin
      modeIn = codes[m]; rdIdxA = 13; rdIdxB = 9;
      cycle("R10");
    end

    summary();
  end

endmodule